// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts down a number of whole seconds and flags the moment the count runs out. Software writes the number of seconds remaining into a counter register, sets the count-enable bit, and from then on every pulse on the one-second tick input lowers the counter by one. When a tick takes the counter from one to zero, a sticky pending flag is set and the counter stays at zero.

The pending flag raises the interrupt line when the interrupt-enable bit is set. It raises the wakeup line when the wakeup-enable bit is set. Software clears the flag by writing a 1 to its bit. A second, calendar-style alarm is not built here. Its enable and interrupt-enable bits are kept as plain storage, and its pending bit always reads as zero.

Access goes through a simple register bus. A write takes effect on the clock edge where the strobe is sampled. Read data is registered and appears on the cycle after the read strobe.

Top module: `cdn_alarm_top`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `wake_o` are low.
- R2: A write to byte offset 0x20 loads the full 32-bit seconds count, and a read of 0x20 returns it. Read data appears on `bus_rdata` one cycle after the read strobe. Control registers keep only bit 0, and their upper bits read as 0.
- R3: When bit 0 of 0x28 (count enable) is 1, each `sec_tick` pulse lowers a nonzero count by exactly one. When count enable is 0, ticks leave the count unchanged.
- R4: The enabled tick that takes the count from 1 to 0 sets the pending flag (bit 0 of 0x30). Later ticks leave the count at 0 with no wrap. A tick on a count that is already 0 does not set the flag.
- R5: Writing 1 to bit 0 of 0x30 clears the pending flag. Writing 0 there leaves the flag unchanged.
- R6: If the flag is set by a tick and cleared by a write in the same cycle, the flag ends up set.
- R7: `irq_o` is high exactly when the pending flag is 1 and bit 0 of 0x2C (interrupt enable) is 1. It follows the flag in the same cycle the flag changes.
- R8: `wake_o` is high exactly when the pending flag is 1 and bit 0 of 0x50 (wakeup enable) is 1.
- R9: A counter write and an enabled tick in the same cycle leave the written value in the counter.
- R10: Bit 0 of 0x44 and bit 0 of 0x48 (calendar alarm enable and interrupt enable) store and read back. Bit 0 of 0x4C reads 0 even after a write of 1. None of these three affects `irq_o` or `wake_o`.
- R11: Reads of an unmapped offset return 0, and writes to one change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read strobe |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Alarm wakeup request |

## Verification
- Counter, control and flag state change on the edge that samples the write or the tick. The value is seen through a read, whose data is due one cycle after that read's strobe.
- `irq_o` and `wake_o` follow the flag and enables with no extra register, so they are valid right after the edge that changed them.
- Inputs are driven on the falling edge. The scoreboard monitor notes a read strobe at the rising edge and compares the popped expected value at the next falling edge.
- Output-pin checks are sampled on the falling edge that follows the stimulus edge.

// File: rtl/cdn_alarm_pkg.sv
package cdn_alarm_pkg;

  localparam logic [7:0] OFS_COUNT     = 8'h20;
  localparam logic [7:0] OFS_COUNT_EN  = 8'h28;
  localparam logic [7:0] OFS_IRQ_EN    = 8'h2C;
  localparam logic [7:0] OFS_PENDING   = 8'h30;
  localparam logic [7:0] OFS_CAL_EN    = 8'h44;
  localparam logic [7:0] OFS_CAL_IRQ   = 8'h48;
  localparam logic [7:0] OFS_CAL_PEND  = 8'h4C;
  localparam logic [7:0] OFS_WAKE_EN   = 8'h50;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_COUNT_EN,
    SEL_IRQ_EN,
    SEL_PENDING,
    SEL_CAL_EN,
    SEL_CAL_IRQ,
    SEL_CAL_PEND,
    SEL_WAKE_EN
  } reg_sel_e;

  typedef struct packed {
    logic count_en;
    logic irq_en;
    logic wake_en;
    logic cal_en;
    logic cal_irq_en;
  } ctrl_t;

  localparam int NUM_OUTS = 2;

endpackage

// File: rtl/cdn_alarm_regs.sv
module cdn_alarm_regs
  import cdn_alarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              pend_q,
  output ctrl_t             ctrl_q,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic              pend_clr,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int PAD_W = DATA_W - 1;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if      (a == ADDR_W'(OFS_COUNT))    s = SEL_COUNT;
    else if (a == ADDR_W'(OFS_COUNT_EN)) s = SEL_COUNT_EN;
    else if (a == ADDR_W'(OFS_IRQ_EN))   s = SEL_IRQ_EN;
    else if (a == ADDR_W'(OFS_PENDING))  s = SEL_PENDING;
    else if (a == ADDR_W'(OFS_CAL_EN))   s = SEL_CAL_EN;
    else if (a == ADDR_W'(OFS_CAL_IRQ))  s = SEL_CAL_IRQ;
    else if (a == ADDR_W'(OFS_CAL_PEND)) s = SEL_CAL_PEND;
    else if (a == ADDR_W'(OFS_WAKE_EN))  s = SEL_WAKE_EN;
    return s;
  endfunction

  reg_sel_e          sel;
  logic              wr_en;
  logic              rd_en;
  ctrl_t             ctrl_d;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  assign sel   = decode(bus_addr);
  assign wr_en = bus_en &  bus_we;
  assign rd_en = bus_en & ~bus_we;

  assign cnt_wr    = wr_en && (sel == SEL_COUNT);
  assign cnt_wdata = bus_wdata[CNT_W-1:0];
  assign pend_clr  = wr_en && (sel == SEL_PENDING) && bus_wdata[0];

  // Control bits: next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      case (sel)
        SEL_COUNT_EN: ctrl_d.count_en   = bus_wdata[0];
        SEL_IRQ_EN:   ctrl_d.irq_en     = bus_wdata[0];
        SEL_WAKE_EN:  ctrl_d.wake_en    = bus_wdata[0];
        SEL_CAL_EN:   ctrl_d.cal_en     = bus_wdata[0];
        SEL_CAL_IRQ:  ctrl_d.cal_irq_en = bus_wdata[0];
        default:      ctrl_d = ctrl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  // Read mux
  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_COUNT:    rdata_d = DATA_W'(cnt_q);
      SEL_COUNT_EN: rdata_d = {{PAD_W{1'b0}}, ctrl_q.count_en};
      SEL_IRQ_EN:   rdata_d = {{PAD_W{1'b0}}, ctrl_q.irq_en};
      SEL_PENDING:  rdata_d = {{PAD_W{1'b0}}, pend_q};
      SEL_CAL_EN:   rdata_d = {{PAD_W{1'b0}}, ctrl_q.cal_en};
      SEL_CAL_IRQ:  rdata_d = {{PAD_W{1'b0}}, ctrl_q.cal_irq_en};
      SEL_WAKE_EN:  rdata_d = {{PAD_W{1'b0}}, ctrl_q.wake_en};
      default:      rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/cdn_alarm_counter.sv
module cdn_alarm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             count_en,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             pend_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pend_q,
  output logic             pend_set
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             pend_d;
  logic             step;
  logic             cnt_ce;

  assign step   = tick && count_en && (cnt_q != '0) && !wr;
  assign cnt_ce = wr || step;

  always_comb begin
    cnt_d    = cnt_q;
    pend_set = 1'b0;
    if (wr) begin
      cnt_d = wdata;
    end else if (step) begin
      cnt_d    = cnt_q - ONE;
      pend_set = (cnt_q == ONE);
    end
  end

  // Set has priority over a same-cycle clear
  always_comb begin
    pend_d = pend_q;
    if (pend_set)      pend_d = 1'b1;
    else if (pend_clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/cdn_alarm_gate.sv
module cdn_alarm_gate #(
  parameter int N = 2
) (
  input  logic         src,
  input  logic [N-1:0] en,
  output logic [N-1:0] out
);

  for (genvar i = 0; i < N; i++) begin : g_out
    assign out[i] = src & en[i];
  end

endmodule

// File: rtl/cdn_alarm_top.sv
module cdn_alarm_top
  import cdn_alarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wake_o
);

  ctrl_t                ctrl_q;
  logic                 cnt_en;
  logic                 irq_en;
  logic                 wake_en;
  logic                 cnt_wr;
  logic [CNT_W-1:0]     cnt_wdata;
  logic                 pend_clr;
  logic [CNT_W-1:0]     cnt_q;
  logic                 pend_q;
  logic                 pend_set;
  logic [NUM_OUTS-1:0]  out_en;
  logic [NUM_OUTS-1:0]  out_vec;

  assign cnt_en  = ctrl_q.count_en;
  assign irq_en  = ctrl_q.irq_en;
  assign wake_en = ctrl_q.wake_en;
  assign out_en  = {wake_en, irq_en};

  cdn_alarm_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .pend_q    (pend_q),
    .ctrl_q    (ctrl_q),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .pend_clr  (pend_clr),
    .bus_rdata (bus_rdata)
  );

  cdn_alarm_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .count_en (cnt_en),
    .wr       (cnt_wr),
    .wdata    (cnt_wdata),
    .pend_clr (pend_clr),
    .cnt_q    (cnt_q),
    .pend_q   (pend_q),
    .pend_set (pend_set)
  );

  cdn_alarm_gate #(
    .N (NUM_OUTS)
  ) u_gate (
    .src (pend_q),
    .en  (out_en),
    .out (out_vec)
  );

  assign irq_o  = out_vec[0];
  assign wake_o = out_vec[1];

endmodule

// File: rtl/cdn_alarm_chk.sv
module cdn_alarm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             cnt_en,
  input logic             irq_en,
  input logic             wake_en,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             pend_q,
  input logic             pend_set,
  input logic             pend_clr,
  input logic             irq_o,
  input logic             wake_o
);

  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && cnt_en && cnt_q != '0 && !cnt_wr) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_wr) |=> $stable(cnt_q));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !cnt_wr) |=> (cnt_q == '0));

  p_zero_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && cnt_en && cnt_q == CNT_W'(1) && !cnt_wr) |=> pend_q);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !pend_set) |=> !pend_q);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !pend_clr) |=> pend_q);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set && pend_clr) |=> pend_q);

  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q && irq_en));

  p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && irq_en) |-> irq_o);

  p_wake_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (pend_q && wake_en));

  p_wake_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && wake_en) |-> wake_o);

endmodule

bind cdn_alarm_top cdn_alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .cnt_en   (cnt_en),
  .irq_en   (irq_en),
  .wake_en  (wake_en),
  .cnt_wr   (cnt_wr),
  .cnt_q    (cnt_q),
  .pend_q   (pend_q),
  .pend_set (pend_set),
  .pend_clr (pend_clr),
  .irq_o    (irq_o),
  .wake_o   (wake_o)
);

// File: tb/cdn_alarm_top_tb.sv
module cdn_alarm_top_tb;

  logic        clk;
  logic        rst_n;
  logic        sec_tick;
  logic        bus_en;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        wake_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  cdn_alarm_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check1(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus write, optionally with a tick in the same cycle
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic t);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; sec_tick = t;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; sec_tick = 1'b0;
  endtask

  // Driver: issue a read and push the expected value to the scoreboard
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
    end
  endtask

  // Monitor: data is due on the cycle after the read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_en && !bus_we) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected read actual=%h expected=none", bus_rdata);
        end else begin
          check1(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check1({31'd0, irq_o},  32'd0, "R1 irq_o");
    check1({31'd0, wake_o}, 32'd0, "R1 wake_o");
    rd(8'h20, 32'd0, "R1 count");
    rd(8'h28, 32'd0, "R1 count_en");
    rd(8'h2C, 32'd0, "R1 irq_en");
    rd(8'h30, 32'd0, "R1 pending");
    rd(8'h50, 32'd0, "R1 wake_en");
    rd(8'h44, 32'd0, "R1 cal_en");

    // R2 load and read back; R11 unmapped
    wr(8'h20, 32'd5, 1'b0);
    rd(8'h20, 32'd5, "R2 count load");
    wr(8'h10, 32'hFFFF_FFFF, 1'b0);
    rd(8'h10, 32'd0, "R11 unmapped read");
    rd(8'h20, 32'd5, "R11 count untouched");

    // R3 disabled ticks
    tick(2);
    rd(8'h20, 32'd5, "R3 disabled hold");

    // R3 enabled countdown; R2 upper bits dropped
    wr(8'h28, 32'hFFFF_FFFF, 1'b0);
    rd(8'h28, 32'd1, "R2 ctrl bit0 only");
    tick(3);
    rd(8'h20, 32'd2, "R3 decrement");

    // R4/R7/R8 expiry
    wr(8'h2C, 32'd1, 1'b0);
    tick(1);
    check1({31'd0, irq_o}, 32'd0, "R7 irq before expiry");
    tick(1);
    check1({31'd0, irq_o},  32'd1, "R7 irq on expiry");
    check1({31'd0, wake_o}, 32'd0, "R8 wake disabled");
    rd(8'h30, 32'd1, "R4 pending set");
    rd(8'h20, 32'd0, "R4 count zero");
    tick(3);
    rd(8'h20, 32'd0, "R4 no wrap");

    // R8 wake enable
    wr(8'h50, 32'd1, 1'b0);
    check1({31'd0, wake_o}, 32'd1, "R8 wake on");

    // R5 clear behaviour
    wr(8'h30, 32'd0, 1'b0);
    rd(8'h30, 32'd1, "R5 write 0 keeps flag");
    wr(8'h30, 32'd1, 1'b0);
    rd(8'h30, 32'd0, "R5 w1c clears");
    check1({31'd0, irq_o},  32'd0, "R7 irq after clear");
    check1({31'd0, wake_o}, 32'd0, "R8 wake after clear");

    // R4 tick at zero does not set
    tick(2);
    rd(8'h30, 32'd0, "R4 zero tick no set");

    // R6 set wins over clear
    wr(8'h20, 32'd1, 1'b0);
    wr(8'h30, 32'd1, 1'b1);
    rd(8'h30, 32'd1, "R6 set wins");
    check1({31'd0, irq_o}, 32'd1, "R6 irq after race");
    wr(8'h30, 32'd1, 1'b0);

    // R9 write beats tick
    wr(8'h20, 32'd7, 1'b1);
    rd(8'h20, 32'd7, "R9 write priority");
    tick(1);
    rd(8'h20, 32'd6, "R9 then decrement");
    rd(8'h30, 32'd0, "R9 no spurious set");

    // R3 full width
    wr(8'h20, 32'hFFFF_FFFF, 1'b0);
    tick(1);
    rd(8'h20, 32'hFFFF_FFFE, "R3 wide decrement");

    // R10 calendar bits
    wr(8'h44, 32'd1, 1'b0);
    wr(8'h48, 32'd1, 1'b0);
    wr(8'h4C, 32'd1, 1'b0);
    rd(8'h44, 32'd1, "R10 cal_en");
    rd(8'h48, 32'd1, "R10 cal_irq_en");
    rd(8'h4C, 32'd0, "R10 cal pending");
    check1({31'd0, irq_o},  32'd0, "R10 irq unaffected");
    check1({31'd0, wake_o}, 32'd0, "R10 wake unaffected");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 reads outstanding actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule